// File: doc/BRIEF.md
# Interrupt Coalescing Credit Controller

This block manages a parameterised set of interrupt vectors. Each vector keeps a signed count of outstanding work credits, a mask, a coalescing countdown and an optional mask-on-assert setting. Event pulses from the datapath raise a vector's count by one per cycle. The vector drives its interrupt line while the countdown is at zero, the vector is unmasked and the count is above zero.

Software reaches every vector through a 32-bit register window on a simple write-strobe bus with a combinational read path. One write to the credit word can do three things at once. It can hand back a signed number of credits, unmask the vector and restart the countdown. Together these let a handler acknowledge its work and rearm the vector in a single access. The countdown steps down on a shared tick input, so one tick source sets the coalescing granularity for all vectors.

Each vector runs a three-state machine. **VS_HOLD** means the countdown is running. **VS_IDLE** means the countdown is at zero and the line is low. **VS_FIRE** means the line is high. The transitions are as follows:
- T_RELOAD goes from any state to VS_HOLD when the next countdown value is nonzero.
- T_EXPIRE goes from VS_HOLD to VS_IDLE when the countdown reaches zero and the firing condition is false.
- T_RAISE goes from VS_IDLE or VS_HOLD to VS_FIRE when the countdown is at zero, the vector is unmasked and the count is positive.
- T_DROP goes from VS_FIRE to VS_IDLE when the vector becomes masked or the count becomes zero or less.

Top module: `icc_top`

## Requirements
- R1: Vector v occupies eight 32-bit words starting at byte address v*32. The word offsets are 0x00 countdown reload value, 0x04 mask, 0x08 credit, 0x0C mask-on-assert and 0x10 countdown remaining. The words at 0x14, 0x18 and 0x1C read as 0, and writes to them change nothing.
- R2: After reset every mask reads 1, every count reads 0, every countdown and reload value reads 0, every mask-on-assert reads 0, and all interrupt lines are low.
- R3: A write to the reload word stores the written value if it is 63 or less. A value above 63 is stored as 63 (6-bit field).
- R4: In the mask word and the mask-on-assert word, bit 0 equal to 1 means masked and 0 means unmasked. A masked vector never raises its line.
- R5: An event pulse adds 1 to the count. A credit write subtracts bits [15:0], taken as a signed 16-bit value. When both fall in the same cycle, both apply on the same edge. The result saturates at 32767 and at -32768.
- R6: A read of the credit word returns the signed 16-bit count in bits [15:0], with zeros above.
- R7: A credit write with bit 16 set unmasks the vector. A credit write with bit 17 set loads the countdown from the reload value. A write with bit 17 set and bit 16 clear leaves the count unchanged.
- R8: The countdown decreases by 1 on each cycle that the tick input is high and the countdown is nonzero. It stays at 0 once it reaches 0, and the remaining word reads its current value.
- R9: The interrupt line is high in the cycle after an edge where the countdown is 0, the vector is unmasked and the count is greater than 0. It stays high while those conditions hold.
- R10: When mask-on-assert is 1, the mask becomes 1 on the same edge that raises the line. The line is therefore high for exactly one cycle.
- R11: Writes to the countdown-remaining word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Countdown step enable shared by all vectors |
| evt_i | input | NVEC | Per-vector event pulse, adds one credit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | NVEC | Per-vector interrupt line |

## Verification
Two operations can hit the same vector's count in one cycle: an event increment and a software credit return. The bench drives an event pulse and a credit write of 2 on the same clock edge with the count at 0. It then expects a count of -1, which shows that both deltas were applied and that neither one blocked the other. The saturating limits are reached with large signed credit writes rather than long event trains. The one-cycle auto-mask pulse is checked edge by edge.

// File: rtl/icc_pkg.sv
`timescale 1ns/1ps
package icc_pkg;
    localparam int WORD_RELOAD = 0;
    localparam int WORD_MASK   = 1;
    localparam int WORD_CREDIT = 2;
    localparam int WORD_AMASK  = 3;
    localparam int WORD_LEFT   = 4;
    localparam int WORD_BITS   = 3;
    localparam int VEC_SPAN_B  = 5;   // 8 words of 4 bytes per vector

    localparam int CR_UNMASK_BIT = 16;
    localparam int CR_RELOAD_BIT = 17;

    typedef enum logic [1:0] {
        VS_IDLE = 2'd0,
        VS_HOLD = 2'd1,
        VS_FIRE = 2'd2
    } vstate_e;

    typedef struct packed {
        logic reload;
        logic mask;
        logic credit;
        logic amask;
    } vwr_s;
endpackage

// File: rtl/icc_decode.sv
`timescale 1ns/1ps
module icc_decode
    import icc_pkg::*;
#(
    parameter int NVEC  = 4,
    localparam int VEC_W  = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int ADDR_W = VEC_W + VEC_SPAN_B
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output vwr_s              wr_o [NVEC],
    output logic [VEC_W-1:0]  vsel_o,
    output logic [WORD_BITS-1:0] word_o
);
    assign vsel_o = addr_i[ADDR_W-1:VEC_SPAN_B];
    assign word_o = addr_i[VEC_SPAN_B-1:2];

    for (genvar v = 0; v < NVEC; v++) begin : g_dec
        logic hit;
        assign hit = wr_en_i && (vsel_o == VEC_W'(v));
        assign wr_o[v].reload = hit && (word_o == WORD_BITS'(WORD_RELOAD));
        assign wr_o[v].mask   = hit && (word_o == WORD_BITS'(WORD_MASK));
        assign wr_o[v].credit = hit && (word_o == WORD_BITS'(WORD_CREDIT));
        assign wr_o[v].amask  = hit && (word_o == WORD_BITS'(WORD_AMASK));
    end
endmodule

// File: rtl/icc_vector.sv
`timescale 1ns/1ps
module icc_vector
    import icc_pkg::*;
#(
    parameter int TMR_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             evt_i,
    input  vwr_s             wr_i,
    input  logic [31:0]      wdata_i,
    output logic             irq_o,
    output logic             mask_o,
    output logic             amsk_o,
    output logic [TMR_W-1:0] init_o,
    output logic [TMR_W-1:0] left_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [TMR_W-1:0] TMR_MAX = '1;
    localparam logic signed [SUM_W-1:0] CMAX =
        SUM_W'((longint'(1) << (CNT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] CMIN = ~CMAX;

    vstate_e                 state_q, state_nxt;
    logic [TMR_W-1:0]        init_q, init_nxt, timer_q, timer_nxt;
    logic                    mask_q, mask_nxt, amsk_q, amsk_nxt;
    logic signed [CNT_W-1:0] count_q, count_nxt;
    logic signed [SUM_W-1:0] cur_w, ret_w, sum_w;
    logic                    reload_w, unmask_w, ret_en_w, fire_ok;

    // credit-word decode
    assign reload_w = wr_i.credit && wdata_i[CR_RELOAD_BIT];
    assign unmask_w = wr_i.credit && wdata_i[CR_UNMASK_BIT];
    assign ret_en_w = wr_i.credit && !(wdata_i[CR_RELOAD_BIT] && !wdata_i[CR_UNMASK_BIT]);

    always_comb begin
        init_nxt = init_q;
        if (wr_i.reload)
            init_nxt = (wdata_i > 32'(TMR_MAX)) ? TMR_MAX : wdata_i[TMR_W-1:0];
        mask_nxt = wr_i.mask ? wdata_i[0] : (unmask_w ? 1'b0 : mask_q);
        amsk_nxt = wr_i.amask ? wdata_i[0] : amsk_q;

        if (reload_w)                    timer_nxt = init_q;
        else if (tick_i && timer_q != '0) timer_nxt = timer_q - 1'b1;
        else                             timer_nxt = timer_q;

        cur_w = {{2{count_q[CNT_W-1]}}, count_q};
        ret_w = ret_en_w ? {{2{wdata_i[CNT_W-1]}}, wdata_i[CNT_W-1:0]} : '0;
        sum_w = cur_w + {{(SUM_W-1){1'b0}}, evt_i} - ret_w;
        if (sum_w > CMAX)      count_nxt = CMAX[CNT_W-1:0];
        else if (sum_w < CMIN) count_nxt = CMIN[CNT_W-1:0];
        else                   count_nxt = sum_w[CNT_W-1:0];

        fire_ok = (timer_nxt == '0) && !mask_nxt && (count_nxt > 0);
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            VS_HOLD: begin
                if (timer_nxt == '0) state_nxt = fire_ok ? VS_FIRE : VS_IDLE; // T_RAISE / T_EXPIRE
            end
            VS_IDLE: begin
                if (timer_nxt != '0) state_nxt = VS_HOLD;                       // T_RELOAD
                else if (fire_ok)    state_nxt = VS_FIRE;                       // T_RAISE
            end
            VS_FIRE: begin
                if (timer_nxt != '0) state_nxt = VS_HOLD;                       // T_RELOAD
                else if (!fire_ok)   state_nxt = VS_IDLE;                       // T_DROP
            end
            default: state_nxt = VS_IDLE;
        endcase
    end

    // state register and per-vector storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VS_IDLE;
            init_q  <= '0;
            timer_q <= '0;
            mask_q  <= 1'b1;
            amsk_q  <= 1'b0;
            count_q <= '0;
        end else begin
            state_q <= state_nxt;
            init_q  <= init_nxt;
            timer_q <= timer_nxt;
            amsk_q  <= amsk_nxt;
            count_q <= count_nxt;
            mask_q  <= (state_nxt == VS_FIRE && state_q != VS_FIRE && amsk_nxt)
                       ? 1'b1 : mask_nxt;
        end
    end

    // outputs
    always_comb begin
        irq_o  = (state_q == VS_FIRE);
        mask_o = mask_q;
        amsk_o = amsk_q;
        init_o = init_q;
        left_o = timer_q;
        cnt_o  = count_q;
    end

    p_fire_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (timer_q == '0 && count_q > 0));

    p_automask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && amsk_q) |-> mask_q);

    p_timer_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && timer_q != '0 && !reload_w) |=> (timer_q == $past(timer_q) - 1'b1));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CMAX[CNT_W-1:0] && !ret_en_w) |=> (count_q == CMAX[CNT_W-1:0]));

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && !wr_i.mask && !unmask_w) |=> !$rose(irq_o));
endmodule

// File: rtl/icc_top.sv
`timescale 1ns/1ps
module icc_top
    import icc_pkg::*;
#(
    parameter int NVEC  = 4,
    parameter int TMR_W = 6,
    parameter int CNT_W = 16,
    localparam int VEC_W  = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int ADDR_W = VEC_W + VEC_SPAN_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NVEC-1:0]   evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [NVEC-1:0]   irq_o
);
    vwr_s                 wr_v [NVEC];
    logic [VEC_W-1:0]     vsel;
    logic [WORD_BITS-1:0] word;
    logic [NVEC-1:0]      mask_v, amsk_v;
    logic [TMR_W-1:0]     init_v [NVEC];
    logic [TMR_W-1:0]     left_v [NVEC];
    logic [CNT_W-1:0]     cnt_v  [NVEC];
    logic [1:0]           unused_byte_lane;

    assign unused_byte_lane = addr_i[1:0];

    icc_decode #(.NVEC(NVEC)) u_dec (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wr_o    (wr_v),
        .vsel_o  (vsel),
        .word_o  (word)
    );

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        icc_vector #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_vec (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .evt_i   (evt_i[v]),
            .wr_i    (wr_v[v]),
            .wdata_i (wdata_i),
            .irq_o   (irq_o[v]),
            .mask_o  (mask_v[v]),
            .amsk_o  (amsk_v[v]),
            .init_o  (init_v[v]),
            .left_o  (left_v[v]),
            .cnt_o   (cnt_v[v])
        );
    end

    always_comb begin
        rdata_o = '0;
        if (int'(vsel) < NVEC) begin
            unique case (word)
                WORD_BITS'(WORD_RELOAD): rdata_o = 32'(init_v[vsel]);
                WORD_BITS'(WORD_MASK):   rdata_o = 32'(mask_v[vsel]);
                WORD_BITS'(WORD_CREDIT): rdata_o = 32'(cnt_v[vsel]);
                WORD_BITS'(WORD_AMASK):  rdata_o = 32'(amsk_v[vsel]);
                WORD_BITS'(WORD_LEFT):   rdata_o = 32'(left_v[vsel]);
                default:                 rdata_o = '0;
            endcase
        end
    end
endmodule

// File: tb/icc_top_bench.sv
`timescale 1ns/1ps
module icc_top_bench;
    localparam int NVEC = 4;
    localparam int AW   = 7;
    localparam int WD_CYC = 200000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic [NVEC-1:0] evt = '0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NVEC-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    icc_top #(.NVEC(NVEC)) u_icc_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .evt_i(evt),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // entry: {do_write, addr, wdata, expected read, requirement number}
    localparam int TN = 14;
    localparam logic [80:0] TBL [TN] = '{
        {1'b0, 8'h04, 32'h0,     32'h1,     8'd2},   // R2 mask after reset
        {1'b0, 8'h08, 32'h0,     32'h0,     8'd2},   // R2 count after reset
        {1'b0, 8'h10, 32'h0,     32'h0,     8'd2},   // R2 countdown after reset
        {1'b0, 8'h0C, 32'h0,     32'h0,     8'd2},   // R2 mask-on-assert after reset
        {1'b1, 8'h00, 32'h25,    32'h25,    8'd1},   // R1 reload word, vector 0
        {1'b1, 8'h20, 32'h1FF,   32'h3F,    8'd3},   // R3 clamp, vector 1
        {1'b1, 8'h14, 32'hDEAD,  32'h0,     8'd1},   // R1 reserved word
        {1'b1, 8'h2C, 32'h1,     32'h1,     8'd4},   // R4 mask-on-assert set, vector 1
        {1'b1, 8'h44, 32'h0,     32'h0,     8'd4},   // R4 unmask, vector 2
        {1'b1, 8'h50, 32'h12,    32'h0,     8'd11},  // R11 remaining write ignored
        {1'b1, 8'h68, 32'hFFFB,  32'h5,     8'd5},   // R5 return -5 -> +5, vector 3
        {1'b1, 8'h68, 32'h7,     32'hFFFE,  8'd6},   // R6 signed readback -2
        {1'b1, 8'h68, 32'h21234, 32'hFFFE,  8'd7},   // R7 reload-only leaves count
        {1'b0, 8'h64, 32'h0,     32'h1,     8'd4}    // R4 vector 3 still masked
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[AW-1:0]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a[AW-1:0];
        #1 chk(rdata, exp, req);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(32'(irq), 32'h0, "R2 irq low in reset");
        rst_n = 1'b1;

        for (int i = 0; i < TN; i++) begin
            if (TBL[i][80]) wr(TBL[i][79:72], TBL[i][71:40]);
            rd_chk(TBL[i][79:72], TBL[i][39:8], $sformatf("R%0d table %0d", TBL[i][7:0], i));
        end

        // R7 unmask via credit bit 16, count untouched
        wr(8'h68, 32'h10000);
        rd_chk(8'h64, 32'h0, "R7 unmask bit");
        rd_chk(8'h68, 32'hFFFE, "R7 unmask keeps count");

        // vector 0: events while masked, then rearm and count down
        @(negedge clk); evt[0] = 1'b1;
        repeat (3) @(negedge clk);
        evt[0] = 1'b0;
        rd_chk(8'h08, 32'h3, "R5 three events");
        chk(32'(irq[0]), 32'h0, "R4 masked vector stays low");
        wr(8'h08, 32'h30000);
        rd_chk(8'h10, 32'd37, "R7 rearm loads countdown");
        rd_chk(8'h04, 32'h0, "R7 rearm unmasks");
        ticks(10);
        rd_chk(8'h10, 32'd27, "R8 ten ticks");
        chk(32'(irq[0]), 32'h0, "R9 low while counting");
        ticks(27);
        #1 chk(32'(irq[0]), 32'h1, "R9 raise at expiry");
        ticks(3);
        rd_chk(8'h10, 32'h0, "R8 holds at zero");
        chk(32'(irq[0]), 32'h1, "R9 stays high");
        wr(8'h08, 32'h3);
        #1 chk(32'(irq[0]), 32'h0, "R9 drop after credits returned");

        // R5 event and credit write on the same edge
        @(negedge clk);
        evt[0] = 1'b1; wr_en = 1'b1; addr = 7'h08; wdata = 32'h2;
        @(negedge clk);
        evt[0] = 1'b0; wr_en = 1'b0;
        rd_chk(8'h08, 32'hFFFF, "R5 same-cycle event and credit");

        // R10 auto-mask one-cycle pulse on vector 1
        wr(8'h24, 32'h0);
        @(negedge clk); evt[1] = 1'b1;
        @(negedge clk); evt[1] = 1'b0;
        #1 chk(32'(irq[1]), 32'h1, "R10 line raised");
        rd_chk(8'h24, 32'h1, "R10 mask set on assert");
        chk(32'(irq[1]), 32'h0, "R10 single-cycle pulse");

        // R5 saturation on vector 2
        wr(8'h48, 32'h8000);
        rd_chk(8'h48, 32'h7FFF, "R5 upper saturation");
        @(negedge clk); evt[2] = 1'b1;
        @(negedge clk); evt[2] = 1'b0;
        rd_chk(8'h48, 32'h7FFF, "R5 event at upper limit");
        wr(8'h48, 32'h7FFF);
        wr(8'h48, 32'h7FFF);
        rd_chk(8'h48, 32'h8001, "R6 negative count");
        wr(8'h48, 32'h1);
        rd_chk(8'h48, 32'h8000, "R5 reaches lower limit");
        wr(8'h48, 32'h1);
        rd_chk(8'h48, 32'h8000, "R5 lower saturation");

        // R2 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk(8'h04, 32'h1, "R2 mask after reset");
        rd_chk(8'h48, 32'h0, "R2 count after reset");
        rd_chk(8'h20, 32'h0, "R2 reload after reset");
        chk(32'(irq), 32'h0, "R2 lines after reset");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(WD_CYC * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule